// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block holds the 10-bit program counter of a small core with a 1K-word program space and chooses, on every clock, where execution goes next. The candidates are the next sequential word, the word after that (used when a conditional test skips one instruction), a 10-bit target carried in a jump or call instruction, a computed target built from a data-path byte for the low half and a separately loaded page register for the top bits, the saved address on the return stack, and the fixed reset and interrupt vectors.

Calls and taken interrupts save the address of the following instruction on an eight-entry return stack. Any of the return flavours restores the program counter from that stack. The stack is a ring: a ninth save silently replaces the oldest entry, and popping an empty stack simply wraps the pointer. The page register that supplies the upper address bits can be written and read back over the 8-bit data bus. Decode and arithmetic sit outside the block and drive its one-bit control inputs. When no control input is raised, the counter holds, which is how the core parks during sleep. The first increment after wake-up moves it to the next word.

Top module: `pcseq_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the edge sets `pc` to 0x000, `stack_ptr` to 0, the page register to 0 (so `hl_rdata` reads 0x00) and every stack entry to 0x000, whatever the other inputs are.
- R2: With no sequencing control raised, `pc` keeps its value across the edge. The first `inc_en` after such an idle stretch yields the held value plus one.
- R3: `inc_en` loads `pc`+1 and `skip_en` loads `pc`+2, both modulo 1024, so 0x3FF increments to 0x000.
- R4: `jump_en` loads `pc` with `dir_addr` and leaves the stack untouched.
- R5: `call_en` saves `pc`+1 on the stack, raises `stack_ptr` by one and loads `pc` with `dir_addr`. `stack_top` then shows the saved value.
- R6: `ret_en` (shared by all return flavours) loads `pc` from `stack_top` and lowers `stack_ptr` by one.
- R7: The stack is a ring of 8 entries with no overflow or underflow flag. A save at pointer 7 wraps the pointer to 0, so a ninth save overwrites the oldest entry. A restore at pointer 0 wraps it to 7.
- R8: `irq_take` saves `pc`+1 on the stack and loads `pc` with the interrupt vector 0x004.
- R9: `hl_wr` loads the page register from `hl_din[1:0]` and ignores `hl_din[7:2]`. `hl_rdata` returns the page register in bits 1:0 with bits 7:2 reading 0.
- R10: `pcl_wr` loads `pc` with {page register, `alu_res`}: bits 9:8 from the page register and bits 7:0 from `alu_res`. When `hl_wr` arrives in the same cycle, the page value in force before that edge is the one used.
- R11: When several controls are raised together, exactly one acts, in the priority order `irq_take`, `ret_en`, `call_en`, `jump_en`, `pcl_wr`, `skip_en`, `inc_en`. The stack never saves and restores on the same edge. `hl_wr` is independent of this order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset (power-on, pin or watchdog) |
| inc_en | input | 1 | Advance to the next word |
| skip_en | input | 1 | Advance by two words |
| jump_en | input | 1 | Load `dir_addr` |
| call_en | input | 1 | Save return address, load `dir_addr` |
| pcl_wr | input | 1 | Software write of the low PC byte |
| ret_en | input | 1 | Restore PC from the stack |
| irq_take | input | 1 | Enter the interrupt vector |
| hl_wr | input | 1 | Write strobe of the page register |
| dir_addr | input | 10 | Target field of a jump or call |
| alu_res | input | 8 | Data-path byte for a low-PC write |
| hl_din | input | 8 | Data bus value for the page register |
| pc | output | 10 | Current program counter |
| hl_rdata | output | 8 | Page register read value |
| stack_top | output | 10 | Most recently saved return address |
| stack_ptr | output | 3 | Ring pointer, next free slot |

## Verification
Every result of this block is registered once, so a control presented before a rising edge shows on `pc`, `stack_ptr`, `stack_top` and `hl_rdata` right after that same edge and not earlier. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each check therefore sees precisely one step of sequencing. For the simultaneous page-register and low-byte write, the check follows that step with a second low-byte write to show when the new page value first takes effect.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;

    localparam int PC_W      = 10;
    localparam int DATA_W    = 8;
    localparam int HL_W      = PC_W - DATA_W;
    localparam int STK_DEPTH = 8;

    typedef logic [PC_W-1:0] pc_t;

    localparam pc_t RESET_VEC = pc_t'(0);
    localparam pc_t IRQ_VEC   = pc_t'(4);

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_INC,
        SRC_SKIP,
        SRC_PCL,
        SRC_JUMP,
        SRC_CALL,
        SRC_RET,
        SRC_IRQ
    } pc_src_e;

    typedef struct packed {
        logic irq;
        logic ret;
        logic call;
        logic jump;
        logic pcl;
        logic skip;
        logic inc;
    } seq_req_t;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_op_t;

    // Fixed priority: interrupt entry first, plain increment last.
    function automatic pc_src_e pick_src(seq_req_t r);
        if (r.irq)       return SRC_IRQ;
        else if (r.ret)  return SRC_RET;
        else if (r.call) return SRC_CALL;
        else if (r.jump) return SRC_JUMP;
        else if (r.pcl)  return SRC_PCL;
        else if (r.skip) return SRC_SKIP;
        else if (r.inc)  return SRC_INC;
        else             return SRC_HOLD;
    endfunction

    function automatic pc_t pc_step(pc_t p, int unsigned n);
        return p + pc_t'(n);
    endfunction

endpackage

// File: rtl/pcseq_arb.sv
`timescale 1ns/1ps
module pcseq_arb
    import pcseq_pkg::*;
(
    input  seq_req_t req,
    output pc_src_e  src,
    output stk_op_t  stk_op
);

    always_comb begin
        src         = pick_src(req);
        stk_op.push = (src == SRC_CALL) || (src == SRC_IRQ);
        stk_op.pop  = (src == SRC_RET);
    end

endmodule

// File: rtl/pcseq_stack.sv
`timescale 1ns/1ps
module pcseq_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic                     pop,
    input  logic [W-1:0]             push_val,
    output logic [W-1:0]             top,
    output logic [$clog2(DEPTH)-1:0] sp
);

    localparam int SP_W = $clog2(DEPTH);
    localparam logic [SP_W-1:0] SP_LAST = SP_W'(DEPTH - 1);

    logic [W-1:0]    slot [DEPTH];
    logic [SP_W-1:0] sp_up;
    logic [SP_W-1:0] sp_dn;

    always_comb begin
        sp_up = (sp == SP_LAST) ? '0 : sp + 1'b1;
        sp_dn = (sp == '0) ? SP_LAST : sp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp_up;
        end else if (pop) begin
            sp <= sp_dn;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (push && (sp == SP_W'(g))) begin
                slot[g] <= push_val;
            end
        end
    end

    assign top = slot[sp_dn];

    AST_STK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R11
    AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (rst)
        push |=> top == $past(push_val)); // R5
    AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (rst)
        (push && sp == SP_LAST) |=> sp == '0); // R7
    AST_POP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pop && sp == '0) |=> sp == SP_LAST); // R7

endmodule

// File: rtl/pcseq_hilatch.sv
`timescale 1ns/1ps
module pcseq_hilatch #(
    parameter int DATA_W = 8,
    parameter int HL_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic [HL_W-1:0]   q,
    output logic [DATA_W-1:0] rdata
);

    logic unused_hi;
    assign unused_hi = ^din[DATA_W-1:HL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr) begin
            q <= din[HL_W-1:0];
        end
    end

    assign rdata = {{(DATA_W-HL_W){1'b0}}, q};

    AST_HL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> rdata == {{(DATA_W-HL_W){1'b0}}, $past(din[HL_W-1:0])}); // R9
    AST_HL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(rdata)); // R9

endmodule

// File: rtl/pcseq_core.sv
`timescale 1ns/1ps
module pcseq_core
    import pcseq_pkg::*;
#(
    parameter int STK_DEPTH_P = pcseq_pkg::STK_DEPTH
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           inc_en,
    input  logic                           skip_en,
    input  logic                           jump_en,
    input  logic                           call_en,
    input  logic                           pcl_wr,
    input  logic                           ret_en,
    input  logic                           irq_take,
    input  logic                           hl_wr,
    input  logic [pcseq_pkg::PC_W-1:0]     dir_addr,
    input  logic [pcseq_pkg::DATA_W-1:0]   alu_res,
    input  logic [pcseq_pkg::DATA_W-1:0]   hl_din,
    output logic [pcseq_pkg::PC_W-1:0]     pc,
    output logic [pcseq_pkg::DATA_W-1:0]   hl_rdata,
    output logic [pcseq_pkg::PC_W-1:0]     stack_top,
    output logic [$clog2(STK_DEPTH_P)-1:0] stack_ptr
);

    seq_req_t        req;
    pc_src_e         src;
    stk_op_t         stk_op;
    logic [HL_W-1:0] hl_q;
    pc_t             pc_next;
    pc_t             ret_addr;

    always_comb begin
        req.irq  = irq_take;
        req.ret  = ret_en;
        req.call = call_en;
        req.jump = jump_en;
        req.pcl  = pcl_wr;
        req.skip = skip_en;
        req.inc  = inc_en;
    end

    pcseq_arb u_arb (
        .req    (req),
        .src    (src),
        .stk_op (stk_op)
    );

    pcseq_hilatch #(
        .DATA_W (DATA_W),
        .HL_W   (HL_W)
    ) u_hl (
        .clk   (clk),
        .rst   (rst),
        .wr    (hl_wr),
        .din   (hl_din),
        .q     (hl_q),
        .rdata (hl_rdata)
    );

    assign ret_addr = pc_step(pc, 1);

    pcseq_stack #(
        .DEPTH (STK_DEPTH_P),
        .W     (PC_W)
    ) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (stk_op.push),
        .pop      (stk_op.pop),
        .push_val (ret_addr),
        .top      (stack_top),
        .sp       (stack_ptr)
    );

    always_comb begin
        case (src)
            SRC_INC:  pc_next = pc_step(pc, 1);
            SRC_SKIP: pc_next = pc_step(pc, 2);
            SRC_PCL:  pc_next = {hl_q, alu_res};
            SRC_JUMP: pc_next = dir_addr;
            SRC_CALL: pc_next = dir_addr;
            SRC_RET:  pc_next = stack_top;
            SRC_IRQ:  pc_next = IRQ_VEC;
            default:  pc_next = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_VEC;
        end else begin
            pc <= pc_next;
        end
    end

    AST_RESET_VEC: assert property (@(posedge clk)
        rst |=> pc == RESET_VEC); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_HOLD) |=> $stable(pc)); // R2
    AST_SKIP_TWO: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_SKIP) |=> pc == pc_t'($past(pc) + pc_t'(2))); // R3
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_JUMP) |=> pc == $past(dir_addr)); // R4
    AST_RET_TOP: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_RET) |=> pc == $past(stack_top)); // R6
    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> pc == IRQ_VEC); // R11
    AST_PCL_JOIN: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PCL) |=> pc[DATA_W-1:0] == $past(alu_res)); // R10

endmodule

// File: tb/sim_pcseq_core.sv
`timescale 1ns/1ps
module sim_pcseq_core;

    logic       clk = 1'b0;
    logic       rst;
    logic       inc_en, skip_en, jump_en, call_en, pcl_wr, ret_en, irq_take, hl_wr;
    logic [9:0] dir_addr;
    logic [7:0] alu_res, hl_din;
    logic [9:0] pc, stack_top;
    logic [7:0] hl_rdata;
    logic [2:0] stack_ptr;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pcseq_core u0 (
        .clk(clk), .rst(rst), .inc_en(inc_en), .skip_en(skip_en), .jump_en(jump_en),
        .call_en(call_en), .pcl_wr(pcl_wr), .ret_en(ret_en), .irq_take(irq_take),
        .hl_wr(hl_wr), .dir_addr(dir_addr), .alu_res(alu_res), .hl_din(hl_din),
        .pc(pc), .hl_rdata(hl_rdata), .stack_top(stack_top), .stack_ptr(stack_ptr)
    );

    // op codes: 0 idle, 1 inc, 2 skip, 3 jump, 4 call, 5 low-pc write, 6 ret, 7 irq, 8 page write
    // entry: {op, arg, expected pc, expected stack_ptr}
    localparam int NV = 17;
    localparam logic [26:0] VEC [NV] = '{
        {4'd1, 10'h000, 10'h001, 3'd0},
        {4'd1, 10'h000, 10'h002, 3'd0},
        {4'd2, 10'h000, 10'h004, 3'd0},
        {4'd3, 10'h155, 10'h155, 3'd0},
        {4'd4, 10'h3F0, 10'h3F0, 3'd1},
        {4'd1, 10'h000, 10'h3F1, 3'd1},
        {4'd7, 10'h000, 10'h004, 3'd2},
        {4'd2, 10'h000, 10'h006, 3'd2},
        {4'd8, 10'h003, 10'h006, 3'd2},
        {4'd5, 10'h02A, 10'h32A, 3'd2},
        {4'd6, 10'h000, 10'h3F2, 3'd1},
        {4'd6, 10'h000, 10'h156, 3'd0},
        {4'd0, 10'h000, 10'h156, 3'd0},
        {4'd8, 10'h0FE, 10'h156, 3'd0},
        {4'd5, 10'h080, 10'h280, 3'd0},
        {4'd3, 10'h3FF, 10'h3FF, 3'd0},
        {4'd1, 10'h000, 10'h000, 3'd0}
    };

    function automatic string op_req(logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R10";
            4'd6: return "R6";
            4'd7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst = 1'b0; inc_en = 1'b0; skip_en = 1'b0; jump_en = 1'b0; call_en = 1'b0;
        pcl_wr = 1'b0; ret_en = 1'b0; irq_take = 1'b0; hl_wr = 1'b0;
        dir_addr = '0; alu_res = '0; hl_din = '0;
    endtask

    task automatic set_op(input logic [3:0] op, input logic [9:0] arg);
        case (op)
            4'd1: inc_en = 1'b1;
            4'd2: skip_en = 1'b1;
            4'd3: begin jump_en = 1'b1; dir_addr = arg; end
            4'd4: begin call_en = 1'b1; dir_addr = arg; end
            4'd5: begin pcl_wr = 1'b1; alu_res = arg[7:0]; end
            4'd6: ret_en = 1'b1;
            4'd7: irq_take = 1'b1;
            4'd8: begin hl_wr = 1'b1; hl_din = arg[7:0]; end
            default: ;
        endcase
    endtask

    // inputs already set at a falling edge; pass one rising edge, sample at next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic op1(input logic [3:0] op, input logic [9:0] arg);
        idle_inputs();
        set_op(op, arg);
        step();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        step();
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        do_reset();
        chk("R1", "pc after reset", 32'(pc), 32'h000);
        chk("R1", "sp after reset", 32'(stack_ptr), 0);
        chk("R1", "page after reset", 32'(hl_rdata), 0);
        chk("R1", "top after reset", 32'(stack_top), 0);

        for (int i = 0; i < NV; i++) begin
            op1(VEC[i][26:23], VEC[i][22:13]);
            chk(op_req(VEC[i][26:23]), $sformatf("vec %0d pc", i), 32'(pc), 32'(VEC[i][12:3]));
            chk(op_req(VEC[i][26:23]), $sformatf("vec %0d sp", i), 32'(stack_ptr), 32'(VEC[i][2:0]));
            if (i == 6) chk("R8", "saved irq return", 32'(stack_top), 32'h3F2);
            if (i == 4) chk("R5", "saved call return", 32'(stack_top), 32'h156);
            if (i == 13) chk("R9", "page readback masks upper bits", 32'(hl_rdata), 32'h02);
        end

        // R1: reset wins over a jump and clears the page register (it holds 2 here)
        idle_inputs();
        rst = 1'b1; jump_en = 1'b1; dir_addr = 10'h123;
        step();
        chk("R1", "reset over jump pc", 32'(pc), 0);
        chk("R1", "reset clears page", 32'(hl_rdata), 0);

        // R9: all-ones data byte keeps only two bits
        op1(4'd8, 10'h0FF);
        chk("R9", "page readback", 32'(hl_rdata), 32'h03);

        // R10: same-cycle page write and low-pc write use the old page value
        do_reset();
        idle_inputs();
        hl_wr = 1'b1; hl_din = 8'h01; pcl_wr = 1'b1; alu_res = 8'h10;
        step();
        chk("R10", "old page used", 32'(pc), 32'h010);
        op1(4'd5, 10'h010);
        chk("R10", "new page used", 32'(pc), 32'h110);

        // R2: idle cycles hold, then increment moves by one
        for (int k = 0; k < 3; k++) op1(4'd0, 10'h000);
        chk("R2", "hold during idle", 32'(pc), 32'h110);
        op1(4'd1, 10'h000);
        chk("R2", "wake increment", 32'(pc), 32'h111);

        // R7: nine calls wrap the ring, oldest slot overwritten
        do_reset();
        for (int k = 0; k < 9; k++) op1(4'd4, 10'(10'h100 + k));
        chk("R7", "sp after nine saves", 32'(stack_ptr), 1);
        chk("R7", "top after nine saves", 32'(stack_top), 32'h108);
        op1(4'd6, 10'h000);
        chk("R7", "first restore", 32'(pc), 32'h108);
        op1(4'd6, 10'h000);
        chk("R7", "pointer wraps 0 to 7", 32'(stack_ptr), 7);
        chk("R7", "second restore", 32'(pc), 32'h107);
        for (int k = 0; k < 6; k++) op1(4'd6, 10'h000);
        chk("R7", "eighth restore", 32'(pc), 32'h101);
        op1(4'd6, 10'h000);
        chk("R7", "ninth restore repeats newest", 32'(pc), 32'h108);

        // R11: priority among simultaneous controls
        do_reset();
        op1(4'd4, 10'h050);
        idle_inputs();
        call_en = 1'b1; ret_en = 1'b1; jump_en = 1'b1; dir_addr = 10'h222;
        step();
        chk("R11", "ret over call", 32'(pc), 32'h001);
        chk("R11", "ret over call sp", 32'(stack_ptr), 0);
        idle_inputs();
        irq_take = 1'b1; ret_en = 1'b1; inc_en = 1'b1; skip_en = 1'b1;
        step();
        chk("R11", "irq over ret", 32'(pc), 32'h004);
        chk("R11", "irq saves next", 32'(stack_top), 32'h002);
        idle_inputs();
        jump_en = 1'b1; dir_addr = 10'h0AB; pcl_wr = 1'b1; alu_res = 8'h11; skip_en = 1'b1;
        step();
        chk("R11", "jump over low-pc write", 32'(pc), 32'h0AB);
        idle_inputs();
        pcl_wr = 1'b1; alu_res = 8'h33; skip_en = 1'b1; inc_en = 1'b1;
        step();
        chk("R11", "low-pc write over skip", 32'(pc), 32'h033);
        idle_inputs();
        skip_en = 1'b1; inc_en = 1'b1;
        step();
        chk("R11", "skip over inc", 32'(pc), 32'h035);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule